// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execution stage of a 32-bit load/store processor pipeline. Each cycle the issue logic presents an operation code, two register operands, a 16-bit immediate and a flag that selects the immediate as the second operand. One clock later the unit returns a registered result, a destination write-enable and an overflow-exception flag. A single adder handles addition, subtraction and both less-than comparisons. A log-depth barrel shifter handles all three shift kinds.

The trapping add and subtract forms check for signed overflow. When overflow occurs, the unit raises the exception flag and withholds the register write in the same cycle. Each immediate form widens the 16-bit field its own way:

- Add and set-less-than copy the immediate's sign bit into the upper half.
- The bitwise forms fill the upper half with zeros.
- Load-upper moves the field into the top half.
- Shifts take their amount from the low five bits of the immediate.

Top module: `alu_ovf_trap`

## Requirements
- R1: While `rst_n` is low, all three outputs read zero. After reset, the outputs for a sample taken at a rising edge appear at that edge and hold for one cycle.
- R2: Code 0 (trapping add) computes `opnd_a` plus the second operand. If both addends have the same sign and the sum's sign differs from them, `out_ovf` is 1 and `out_wr_en` is 0. Otherwise `out_wr_en` is 1 and `out_result` holds the sum.
- R3: Code 2 (trapping subtract) always uses `opnd_b` and ignores `imm_sel`. If the operands' signs differ and the difference's sign differs from `opnd_a`'s, `out_ovf` is 1 and `out_wr_en` is 0.
- R4: Codes 1 (wrapping add) and 3 (wrapping subtract) never raise `out_ovf`. They always assert `out_wr_en` with the 32-bit wrapped value. Code 3 uses `opnd_b` whatever the value of `imm_sel`.
- R5: For codes 0 and 1 with `imm_sel` set, the second operand is the sign-extended immediate, so 0xFFFF subtracts one.
- R6: Codes 4 (AND), 5 (OR) and 6 (XOR) with `imm_sel` set use the zero-extended immediate. An AND-immediate result therefore has bits 31..16 clear.
- R7: Code 7 (NOR) returns the complement of `opnd_a | opnd_b` and ignores `imm_sel`. Two zero operands give 0xFFFFFFFF.
- R8: Code 8 (signed less-than) and code 9 (unsigned less-than) write exactly 0 or 1. With `imm_sel` set, the immediate is sign-extended before either comparison, so for code 9 an immediate of 0xC000 compares against 0xFFFFC000.
- R9: Code 10 (load upper) returns the immediate in bits 31..16 and zeros in bits 15..0, whatever the operands are.
- R10: Codes 11 (left logical), 12 (right logical) and 13 (right arithmetic) shift `opnd_b`. The amount is `imm[4:0]` when `imm_sel` is set and `opnd_a[4:0]` otherwise. Logical shifts fill with zeros, and the arithmetic shift fills with bit 31.
- R11: `out_ovf` is 1 only for codes 0 and 2. Codes 14 and 15, or `in_valid` low, give `out_wr_en` 0, `out_ovf` 0 and `out_result` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| opnd_a | input | 32 | First register operand / variable shift amount |
| opnd_b | input | 32 | Second register operand / shift source |
| imm | input | 16 | Immediate field |
| imm_sel | input | 1 | Use the immediate as second operand or shift amount |
| out_result | output | 32 | Registered result |
| out_wr_en | output | 1 | Destination write-enable |
| out_ovf | output | 1 | Signed-overflow exception |

## Verification
The overflow exception and the suppression of the destination write fall in the same output cycle. They must always appear together, and only for the two trapping codes. The sweep provokes this by pairing the operand corners 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, so that sums and differences cross the signed boundary in both directions. The wrapping forms see the same pairs, and the bench judges every cycle against a 64-bit arithmetic reference in which an out-of-range signed sum both raises the flag and clears the enable.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD_T  = 4'd0,
        OP_ADD_W  = 4'd1,
        OP_SUB_T  = 4'd2,
        OP_SUB_W  = 4'd3,
        OP_AND    = 4'd4,
        OP_OR     = 4'd5,
        OP_XOR    = 4'd6,
        OP_NOR    = 4'd7,
        OP_SLT    = 4'd8,
        OP_SLTU   = 4'd9,
        OP_LUI    = 4'd10,
        OP_SHL    = 4'd11,
        OP_SHR    = 4'd12,
        OP_SHRA   = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } alu_op_e;

    function automatic logic op_traps(input alu_op_e op);
        return (op == OP_ADD_T) || (op == OP_SUB_T);
    endfunction

    function automatic logic op_subtracts(input alu_op_e op);
        return (op == OP_SUB_T) || (op == OP_SUB_W) ||
               (op == OP_SLT)   || (op == OP_SLTU);
    endfunction

    function automatic logic op_known(input alu_op_e op);
        return (op != OP_RSV14) && (op != OP_RSV15);
    endfunction
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  alu_op_e             op,
    input  logic                imm_sel,
    input  logic [IMM_W-1:0]    imm,
    input  logic [DATA_W-1:0]   reg_b,
    output logic [DATA_W-1:0]   opnd_b_eff
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_zx;

    always_comb begin
        imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
        imm_zx = {{PAD_W{1'b0}}, imm};
        opnd_b_eff = reg_b;
        if (imm_sel) begin
            unique case (op)
                OP_ADD_T, OP_ADD_W, OP_SLT, OP_SLTU: opnd_b_eff = imm_sx;
                OP_AND, OP_OR, OP_XOR:               opnd_b_eff = imm_zx;
                default:                             opnd_b_eff = reg_b;
            endcase
        end
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out,
    output logic              sgn_ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] rhs_inv;

    always_comb begin
        rhs_inv = do_sub ? ~rhs : rhs;
        {carry_out, sum} = {1'b0, lhs} + {1'b0, rhs_inv} + {{DATA_W{1'b0}}, do_sub};
        sgn_ovf = (lhs[MSB] == rhs_inv[MSB]) && (sum[MSB] != lhs[MSB]);
    end
endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
    parameter int DATA_W = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  src,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               to_left,
    input  logic               arith,
    output logic [DATA_W-1:0]  dst
);
    logic [DATA_W-1:0] src_rev;
    logic [DATA_W-1:0] out_rev;
    logic [DATA_W-1:0] stage [0:SHAMT_W];
    logic              fill_bit;

    assign fill_bit = arith & ~to_left & src[DATA_W-1];

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign src_rev[i] = src[DATA_W-1-i];
        assign out_rev[i] = stage[SHAMT_W][DATA_W-1-i];
    end

    assign stage[0] = to_left ? src_rev : src;

    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill_bit}}, stage[s][DATA_W-1:STEP]}
                                   : stage[s];
    end

    assign dst = to_left ? out_rev : stage[SHAMT_W];
endmodule

// File: rtl/alu_ovf_trap.sv
module alu_ovf_trap
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_sel,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr_en,
    output logic              out_ovf
);
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int LOW_W   = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr_en;
        logic              ovf;
    } alu_reg_t;

    alu_op_e           op;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] as_sum;
    logic              as_carry;
    logic              as_ovf;
    logic [DATA_W-1:0] sh_out;
    logic [SHAMT_W-1:0] sh_amt;
    logic              less_s;
    logic              less_u;
    alu_reg_t          st_d;
    alu_reg_t          st_q;

    assign op     = alu_op_e'(op_code);
    assign sh_amt = imm_sel ? imm[SHAMT_W-1:0] : opnd_a[SHAMT_W-1:0];

    alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .op         (op),
        .imm_sel    (imm_sel),
        .imm        (imm),
        .reg_b      (opnd_b),
        .opnd_b_eff (b_eff)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .lhs       (opnd_a),
        .rhs       (b_eff),
        .do_sub    (op_subtracts(op)),
        .sum       (as_sum),
        .carry_out (as_carry),
        .sgn_ovf   (as_ovf)
    );

    alu_barrel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .src     (opnd_b),
        .amt     (sh_amt),
        .to_left (op == OP_SHL),
        .arith   (op == OP_SHRA),
        .dst     (sh_out)
    );

    // Signed less-than from the sign of the difference corrected by overflow;
    // unsigned less-than from a missing carry (borrow) out of the subtraction.
    assign less_s = as_sum[DATA_W-1] ^ as_ovf;
    assign less_u = ~as_carry;

    always_comb begin
        st_d = '0;
        if (in_valid && op_known(op)) begin
            unique case (op)
                OP_ADD_T, OP_ADD_W,
                OP_SUB_T, OP_SUB_W: st_d.result = as_sum;
                OP_AND:             st_d.result = opnd_a & b_eff;
                OP_OR:              st_d.result = opnd_a | b_eff;
                OP_XOR:             st_d.result = opnd_a ^ b_eff;
                OP_NOR:             st_d.result = ~(opnd_a | opnd_b);
                OP_SLT:             st_d.result = {{(DATA_W-1){1'b0}}, less_s};
                OP_SLTU:            st_d.result = {{(DATA_W-1){1'b0}}, less_u};
                OP_LUI:             st_d.result = {imm, {LOW_W{1'b0}}};
                OP_SHL, OP_SHR,
                OP_SHRA:            st_d.result = sh_out;
                default:            st_d.result = '0;
            endcase
            st_d.ovf   = op_traps(op) && as_ovf;
            st_d.wr_en = !st_d.ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_result = st_q.result;
    assign out_wr_en  = st_q.wr_en;
    assign out_ovf    = st_q.ovf;
endmodule

// File: rtl/alu_ovf_trap_chk.sv
module alu_ovf_trap_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_code,
    input logic              imm_sel,
    input logic [DATA_W-1:0] out_result,
    input logic              out_wr_en,
    input logic              out_ovf
);
    AST_OVF_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> !out_wr_en); // R2

    AST_OVF_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_code) != 4'd0 && $past(op_code) != 4'd2) |-> !out_ovf); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!out_wr_en && !out_ovf && out_result == '0)); // R11

    AST_WRAP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && ($past(op_code) == 4'd1 || $past(op_code) == 4'd3))
        |-> out_wr_en); // R4

    AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && ($past(op_code) == 4'd8 || $past(op_code) == 4'd9))
        |-> (out_result[DATA_W-1:1] == '0)); // R8

    AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(op_code) == 4'd10)
        |-> (out_result[DATA_W-IMM_W-1:0] == '0)); // R9

    AST_ANDI_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(op_code) == 4'd4 && $past(imm_sel))
        |-> (out_result[DATA_W-1:IMM_W] == '0)); // R6
endmodule

bind alu_ovf_trap alu_ovf_trap_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .imm_sel    (imm_sel),
    .out_result (out_result),
    .out_wr_en  (out_wr_en),
    .out_ovf    (out_ovf)
);

// File: tb/tb_alu_ovf_trap.sv
module tb_alu_ovf_trap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm = '0;
    logic        imm_sel = 1'b0;
    logic [31:0] out_result;
    logic        out_wr_en;
    logic        out_ovf;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_ovf_trap dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .imm_sel(imm_sel),
        .out_result(out_result), .out_wr_en(out_wr_en), .out_ovf(out_ovf)
    );

    // Reference: {wr_en, ovf, result}
    function automatic logic [33:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] im,
                                          input logic sel, input logic vld);
        logic [31:0] sx, zx, bb, r;
        logic [4:0]  sh;
        longint      s;
        logic        ov, wr;
        sx = {{16{im[15]}}, im};
        zx = {16'h0, im};
        sh = sel ? im[4:0] : a[4:0];
        r = '0; ov = 1'b0; wr = 1'b1;
        case (op)
            4'd0, 4'd1: begin
                bb = sel ? sx : b;
                r  = a + bb;
                s  = longint'($signed(a)) + longint'($signed(bb));
                ov = (op == 4'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd2, 4'd3: begin
                r  = a - b;
                s  = longint'($signed(a)) - longint'($signed(b));
                ov = (op == 4'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd4:  r = a & (sel ? zx : b);
            4'd5:  r = a | (sel ? zx : b);
            4'd6:  r = a ^ (sel ? zx : b);
            4'd7:  r = ~(a | b);
            4'd8:  r = {31'b0, $signed(a) < $signed(sel ? sx : b)};
            4'd9:  r = {31'b0, a < (sel ? sx : b)};
            4'd10: r = {im, 16'h0};
            4'd11: r = b << sh;
            4'd12: r = b >> sh;
            4'd13: r = $unsigned($signed(b) >>> sh);
            default: wr = 1'b0;
        endcase
        if (!vld) begin
            r = '0; ov = 1'b0; wr = 1'b0;
        end
        if (ov) wr = 1'b0;
        return {wr, ov, r};
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd2: return "R3";
            4'd1, 4'd3: return "R4";
            4'd4, 4'd5, 4'd6: return "R6";
            4'd7: return "R7";
            4'd8, 4'd9: return "R8";
            4'd10: return "R9";
            4'd11, 4'd12, 4'd13: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic compare(input string req, input logic [33:0] got, input logic [33:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h sel=%0b: got wr=%0b ovf=%0b res=%h expected wr=%0b ovf=%0b res=%h",
                     req, op_code, opnd_a, opnd_b, imm, imm_sel,
                     got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Drive on a falling edge, result registers at the next rising edge,
    // sample at the following falling edge.
    task automatic issue(input string req, input logic vld, input logic [3:0] op,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic sel);
        in_valid = vld; op_code = op; opnd_a = a; opnd_b = b; imm = im; imm_sel = sel;
        @(negedge clk);
        compare(req, {out_wr_en, out_ovf, out_result}, model(op, a, b, im, sel, vld));
    endtask

    function automatic logic [31:0] corner(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return 32'h0000_0023;
        endcase
    endfunction

    function automatic logic [15:0] imm_corner(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            default: return 16'hC000;
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if ({out_wr_en, out_ovf, out_result} !== 34'h0) begin
            failures++;
            $display("FAIL R1 reset: got wr=%0b ovf=%0b res=%h expected 0 0 0",
                     out_wr_en, out_ovf, out_result);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        issue("R2",  1'b1, 4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0);          // +overflow
        issue("R2",  1'b1, 4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0);  // -overflow
        issue("R2",  1'b1, 4'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0);  // mixed signs
        issue("R3",  1'b1, 4'd2, 32'h8000_0000, 32'h1, 16'h0, 1'b0);          // overflow
        issue("R3",  1'b1, 4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0);  // overflow
        issue("R3",  1'b1, 4'd2, 32'h5, 32'h3, 16'hFFFF, 1'b1);               // imm ignored
        issue("R4",  1'b1, 4'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0);          // wraps, writes
        issue("R4",  1'b1, 4'd3, 32'h8000_0000, 32'h1, 16'h1234, 1'b1);       // wraps, imm ignored
        issue("R5",  1'b1, 4'd1, 32'h5, 32'hDEAD_BEEF, 16'hFFFF, 1'b1);       // 5 + (-1) = 4
        issue("R5",  1'b1, 4'd0, 32'h8000_0000, 32'h0, 16'hFFFF, 1'b1);       // traps
        issue("R6",  1'b1, 4'd4, 32'hFFFF_FFFF, 32'h0, 16'h80FF, 1'b1);       // high half clear
        issue("R6",  1'b1, 4'd5, 32'h1234_0000, 32'h0, 16'h8001, 1'b1);
        issue("R7",  1'b1, 4'd7, 32'h0, 32'h0, 16'hFFFF, 1'b1);               // all ones
        issue("R8",  1'b1, 4'd9, 32'hFFFF_0000, 32'h0, 16'hC000, 1'b1);       // < 0xFFFFC000
        issue("R8",  1'b1, 4'd9, 32'hFFFF_C000, 32'h0, 16'hC000, 1'b1);       // equal -> 0
        issue("R8",  1'b1, 4'd8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0);
        issue("R9",  1'b1, 4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hA5C3, 1'b0);
        issue("R10", 1'b1, 4'd13, 32'hFFFF_FFE3, 32'h8000_0010, 16'h0, 1'b0); // amount 3
        issue("R10", 1'b1, 4'd12, 32'h0, 32'h8000_0010, 16'hFFE4, 1'b1);      // amount 4
        issue("R10", 1'b1, 4'd11, 32'h0000_003F, 32'h0000_0001, 16'h0, 1'b0); // amount 31
        issue("R11", 1'b1, 4'd14, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0);
        issue("R11", 1'b1, 4'd15, 32'h1, 32'h1, 16'h1, 1'b1);
        issue("R11", 1'b0, 4'd0,  32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0);         // not valid

        // Sweep: every code, every corner pair, both operand selects
        for (int op = 0; op < 16; op++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 6; ib++) begin
                    for (int sel = 0; sel < 2; sel++) begin
                        issue(req_of(4'(op)), 1'b1, 4'(op), corner(ia), corner(ib),
                              imm_corner((ia + ib) % 6), sel[0]);
                    end
                end
            end
        end

        // Random operands, valid toggling
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] rop;
            rop = 4'($urandom_range(0, 15));
            issue(req_of(rop), ($urandom_range(0, 7) != 0), rop, $urandom, $urandom,
                  16'($urandom), 1'($urandom));
        end

        // R1: reset clears outputs again
        in_valid = 1'b1; op_code = 4'd7; opnd_a = '0; opnd_b = '0; imm_sel = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if ({out_wr_en, out_ovf, out_result} !== 34'h0) begin
            failures++;
            $display("FAIL R1 mid-run reset: got wr=%0b ovf=%0b res=%h expected 0 0 0",
                     out_wr_en, out_ovf, out_result);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule